// File: doc/BRIEF.md
# Ping-Pong Sample Buffer Controller

This block steers an incoming sample stream into two memory buffers in turn. Software programs a base address for each buffer and one size, counted in samples. It then arms each buffer to mark it empty and ready. The block turns every accepted sample into a one-cycle write strobe with a byte address. The address steps by four bytes through the active buffer. When a buffer has taken its programmed number of samples, the block marks it full, drops its ready mark and moves on to the other buffer.

Software watches the per-buffer full flags and re-arms a buffer after draining it. A status word shows which buffer takes the next sample. It also holds two sticky error bits, both cleared by writing 1. The overrun bit records samples discarded because no buffer was ready. The bandwidth bit records samples that arrived while the previous write was still waiting for its acknowledge.

Top module: `pingpong_bufctl`

## Requirements
- R1: After reset, buffer 1 is the next target and neither buffer is ready or full. Both error bits are clear and no write strobe is issued. The status word, at register index 0, reads 0x01.
- R2: An accepted sample gives `mem_wr` high for one cycle, starting at the clock edge after the cycle in which `smp_valid` was high. `mem_addr` is the target buffer's base plus 4 times the number of samples already written into that buffer.
- R3: When a buffer takes its SIZE-th sample, three things happen. Its ready bit clears, its full flag sets, and the next target becomes the other buffer. The sample count restarts at 0. A SIZE of 0 behaves as 1.
- R4: Status bit 0 is 1 when buffer 1 is the next target and 0 when buffer 2 is. The same value drives the `active_is_b1` output.
- R5: A sample can arrive while the current target is not ready and the other buffer is ready. That sample is written into the other buffer, and that buffer becomes the target.
- R6: A sample that arrives while neither buffer is ready produces no write. It sets the sticky overrun bit, which is status bit 1 and also the `overrun` output.
- R7: A sample can arrive while an earlier write strobe has had no `wr_ack`, with no `wr_ack` in the same cycle. That sample sets the sticky bandwidth bit, which is status bit 2 and also the `bw_err` output. A sample with `wr_ack` high does not set it.
- R8: Writing status (index 0) with bit 1 or bit 2 set clears the matching error bit. Writing 0 to those bits leaves them unchanged. A set in the same cycle wins over a clear.
- R9: Writing the arm register (index 1) with bit 0 set marks buffer 1 ready and clears its full flag. Bit 1 does the same for buffer 2. Bits written as 0 have no effect. Full flags are status bits 3 and 4, and ready bits are status bits 5 and 6. The `buf_full` output carries the full flags, with bit 0 for buffer 1.
- R10: Base 1 (index 2), base 2 (index 3) and SIZE (index 4) read back the last values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| smp_valid | input | 1 | A sample arrives this cycle |
| wr_ack | input | 1 | Memory accepted the outstanding write |
| mem_addr | output | AW | Byte address of the current write |
| mem_wr | output | 1 | Write strobe, one cycle per sample |
| buf_full | output | 2 | Full flags, bit 0 for buffer 1 |
| active_is_b1 | output | 1 | Buffer 1 takes the next sample |
| overrun | output | 1 | Sticky overrun error |
| bw_err | output | 1 | Sticky bandwidth error |

## Verification
The hardest state to reach is a mismatch between the target pointer and the ready bits. That happens when the current target is not ready and the other buffer is. With in-order software it never arises, because a fill always hands over to the other buffer. The stimulus forces it on purpose. It fills buffer 1 and leaves buffer 2 unarmed, then re-arms only buffer 1, so the next sample has to cross back. Size 0 is reached by reprogramming SIZE partway through a buffer. The bandwidth error is reached by holding back the acknowledge for one sample.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [2:0] {
    RG_STAT  = 3'd0,
    RG_ARM   = 3'd1,
    RG_BASE1 = 3'd2,
    RG_BASE2 = 3'd3,
    RG_SIZE  = 3'd4
  } reg_idx_e;

  localparam int ST_B1NEXT = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_BW     = 2;
  localparam int ST_FULL0  = 3;
  localparam int ST_RDY0   = 5;

  // byte address of a sample slot: one 32-bit word per sample
  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [31:0] cnt);
    return base + (cnt << 2);
  endfunction

  // true when the sample at position cnt completes a buffer of size entries
  function automatic logic slot_is_last(input logic [31:0] cnt, input logic [31:0] size);
    return (size == 32'd0) || ((cnt + 32'd1) >= size);
  endfunction

endpackage

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [2:0]           addr,
  input  logic [31:0]          wdata,
  input  logic                 set_ovr,
  input  logic                 set_bw,
  output logic [1:0][AW-1:0]   base,
  output logic [CW-1:0]        size,
  output logic [1:0]           arm,
  output logic                 ovr,
  output logic                 bw
);

  logic wr_stat;
  assign wr_stat = we && (addr == RG_STAT);

  for (genvar g = 0; g < 2; g++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rst_n) base[g] <= '0;
      else if (we && (addr == 3'(RG_BASE1 + g))) base[g] <= wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) size <= '0;
    else if (we && (addr == RG_SIZE)) size <= wdata[CW-1:0];
  end

  assign arm = (we && (addr == RG_ARM)) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr <= 1'b0;
      bw  <= 1'b0;
    end else begin
      if (set_ovr) ovr <= 1'b1;
      else if (wr_stat && wdata[ST_OVR]) ovr <= 1'b0;
      if (set_bw) bw <= 1'b1;
      else if (wr_stat && wdata[ST_BW]) bw <= 1'b0;
    end
  end

  assert_w1c_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[ST_OVR] && !set_ovr) |=> !ovr);
  assert_w1c_bw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[ST_BW] && !set_bw) |=> !bw);
  assert_sticky_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovr |=> ovr);

endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic                 wr_ack,
  input  logic [1:0][AW-1:0]   base,
  input  logic [CW-1:0]        size,
  input  logic [1:0]           arm,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_wr,
  output logic                 act,
  output logic [1:0]           rdy,
  output logic [1:0]           full,
  output logic                 drop_evt,
  output logic                 bw_evt
);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          take, last, fill_evt, tgt;

  // prefer the current target; fall back to the other buffer if it is ready
  assign tgt      = rdy[act] ? act : ~act;
  assign take     = smp_valid && (rdy[0] || rdy[1]);
  assign drop_evt = smp_valid && !rdy[0] && !rdy[1];
  assign bw_evt   = smp_valid && pend_q && !wr_ack;
  assign last     = slot_is_last(32'(cnt_q), 32'(size));
  assign fill_evt = take && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr   <= 1'b0;
      mem_addr <= '0;
      cnt_q    <= '0;
      act      <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      mem_wr <= take;
      if (take) begin
        mem_addr <= AW'(slot_addr(32'(base[tgt]), 32'(cnt_q)));
        cnt_q    <= last ? '0 : cnt_q + 1'b1;
        act      <= last ? ~tgt : tgt;
      end
      if (take) pend_q <= 1'b1;
      else if (wr_ack) pend_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy[g]  <= 1'b0;
        full[g] <= 1'b0;
      end else if (arm[g]) begin
        rdy[g]  <= 1'b1;
        full[g] <= 1'b0;
      end else if (fill_evt && (tgt == 1'(g))) begin
        rdy[g]  <= 1'b0;
        full[g] <= 1'b1;
      end
    end
  end

  assert_write_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(smp_valid));
  assert_drop_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !mem_wr);
  assert_fill_hands_over_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (act != $past(tgt)));
  assert_full_raised_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !arm[tgt]) |=> ($countones(full) >= 1));

endmodule

// File: rtl/pingpong_bufctl.sv
module pingpong_bufctl
  import pp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          smp_valid,
  input  logic          wr_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic [1:0]    buf_full,
  output logic          active_is_b1,
  output logic          overrun,
  output logic          bw_err
);

  logic [1:0][AW-1:0] base;
  logic [CW-1:0]      size;
  logic [1:0]         arm, rdy;
  logic               act, drop_evt, bw_evt;

  pp_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .set_ovr(drop_evt), .set_bw(bw_evt), .base(base), .size(size), .arm(arm),
    .ovr(overrun), .bw(bw_err)
  );

  pp_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .wr_ack(wr_ack),
    .base(base), .size(size), .arm(arm), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .act(act), .rdy(rdy), .full(buf_full), .drop_evt(drop_evt), .bw_evt(bw_evt)
  );

  assign active_is_b1 = ~act;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RG_STAT: begin
        cfg_rdata[ST_B1NEXT]          = ~act;
        cfg_rdata[ST_OVR]             = overrun;
        cfg_rdata[ST_BW]              = bw_err;
        cfg_rdata[ST_FULL0 +: 2]      = buf_full;
        cfg_rdata[ST_RDY0 +: 2]       = rdy;
      end
      RG_BASE1: cfg_rdata = 32'(base[0]);
      RG_BASE2: cfg_rdata = 32'(base[1]);
      RG_SIZE:  cfg_rdata = 32'(size);
      default:  cfg_rdata = '0;
    endcase
  end

  assert_status_tracks_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == RG_STAT) |-> (cfg_rdata[ST_B1NEXT] == active_is_b1));

endmodule

// File: tb/sim_pingpong_bufctl.sv
`timescale 1ns/1ps
module sim_pingpong_bufctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        smp_valid = 1'b0;
  logic        wr_ack = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_wr;
  logic [1:0]  buf_full;
  logic        active_is_b1, overrun, bw_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pingpong_bufctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smp_valid(smp_valid),
    .wr_ack(wr_ack), .mem_addr(mem_addr), .mem_wr(mem_wr), .buf_full(buf_full),
    .active_is_b1(active_is_b1), .overrun(overrun), .bw_err(bw_err)
  );

  // expected status word built from the requirement bit positions
  function automatic logic [31:0] st(bit b1, bit ov, bit bw, bit f1, bit f2, bit r1, bit r2);
    return {25'd0, r2, r1, f2, f1, bw, ov, b1};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cfg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic push(logic ack);
    @(negedge clk);
    smp_valid = 1'b1; wr_ack = ack;
    @(negedge clk);
    smp_valid = 1'b0; wr_ack = 1'b0;
  endtask

  // {expected strobe, expected address, expected status}
  localparam logic [40:0] VEC [7] = '{
    {1'b1, 32'h0000_1000, 8'h61},
    {1'b1, 32'h0000_1004, 8'h61},
    {1'b1, 32'h0000_1008, 8'h48},
    {1'b1, 32'h0000_2000, 8'h48},
    {1'b1, 32'h0000_2004, 8'h48},
    {1'b1, 32'h0000_2008, 8'h19},
    {1'b0, 32'h0000_0000, 8'h1B}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, s);
    check("R1 status", s, st(1,0,0,0,0,0,0));
    check("R1 strobe", 32'(mem_wr), 32'd0);
    check("R1 full", 32'(buf_full), 32'd0);

    // program and arm
    cfg_wr(3'd2, 32'h1000);
    cfg_wr(3'd3, 32'h2000);
    cfg_wr(3'd4, 32'd3);
    cfg_wr(3'd1, 32'h3);

    // R2 R3 R4 R6 main stream
    for (int i = 0; i < 7; i++) begin
      push(1'b1);
      check("R2 strobe", 32'(mem_wr), 32'(VEC[i][40]));
      if (VEC[i][40]) check("R2 address", mem_addr, VEC[i][39:8]);
      rd(3'd0, s);
      check("R3 R4 R6 status", s, {24'd0, VEC[i][7:0]});
    end
    check("R9 full port", 32'(buf_full), 32'h3);
    check("R4 port", 32'(active_is_b1), 32'd1);
    check("R6 port", 32'(overrun), 32'd1);

    // R8 write-one-to-clear
    cfg_wr(3'd0, 32'h0);
    rd(3'd0, s); check("R8 zero keeps", s, st(1,1,0,1,1,0,0));
    cfg_wr(3'd0, 32'h2);
    rd(3'd0, s); check("R8 clear ovr", s, st(1,0,0,1,1,0,0));

    // R9 arm
    cfg_wr(3'd1, 32'h0);
    rd(3'd0, s); check("R9 zero no effect", s, st(1,0,0,1,1,0,0));
    cfg_wr(3'd1, 32'h1);
    rd(3'd0, s); check("R9 arm b1", s, st(1,0,0,0,1,1,0));

    // fill buffer 1 again, buffer 2 stays unarmed
    for (int i = 0; i < 3; i++) begin
      push(1'b1);
      check("R2 refill addr", mem_addr, 32'h1000 + 32'(4 * i));
    end
    rd(3'd0, s); check("R3 refill done", s, st(0,0,0,1,1,0,0));

    // R5 target not ready, other buffer ready
    cfg_wr(3'd1, 32'h1);
    rd(3'd0, s); check("R5 pre", s, st(0,0,0,0,1,1,0));
    push(1'b1);
    check("R5 strobe", 32'(mem_wr), 32'd1);
    check("R5 address", mem_addr, 32'h1000);
    rd(3'd0, s); check("R5 status", s, st(1,0,0,0,1,1,0));

    // R7 sample before ack
    push(1'b0);
    check("R7 address", mem_addr, 32'h1004);
    rd(3'd0, s); check("R7 bw set", s, st(1,0,1,0,1,1,0));
    check("R7 port", 32'(bw_err), 32'd1);
    cfg_wr(3'd0, 32'h4);
    rd(3'd0, s); check("R8 clear bw", s, st(1,0,0,0,1,1,0));

    // R3 size 0 behaves as 1
    cfg_wr(3'd4, 32'd0);
    push(1'b1);
    check("R3 size0 addr", mem_addr, 32'h1008);
    rd(3'd0, s); check("R3 size0 fill", s, st(0,0,0,1,1,0,0));
    cfg_wr(3'd1, 32'h2);
    rd(3'd0, s); check("R9 arm b2", s, st(0,0,0,1,0,0,1));
    push(1'b1);
    check("R3 size0 b2 addr", mem_addr, 32'h2000);
    rd(3'd0, s); check("R3 size0 b2 fill", s, st(1,0,0,1,1,0,0));

    // R10 readback
    rd(3'd2, s); check("R10 base1", s, 32'h1000);
    rd(3'd3, s); check("R10 base2", s, 32'h2000);
    rd(3'd4, s); check("R10 size", s, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule